// File: doc/BRIEF.md
# Translation Miss Assist Register Loader

When an address translation finds no matching entry, this block fills a set of assist registers with a ready-made candidate entry. A miss handler can then complete that entry and write it into the translation table. The fill uses three sources. A template input supplies the default table select, page size, storage attributes and a selector for which process ID goes into the entry. The faulting effective address supplies the page number. A round-robin way pointer suggests which way to replace.

The block also latches the faulting address into a fault address register. It builds a syndrome word that flags store accesses and accesses made in external-ID mode. It outputs the byte size of the default page. Every update lands in the clock cycle after the miss strobe, and the outputs hold their values until the next strobe. The way count is given as a power-of-two exponent, so a way count of one (exponent 0) is allowed.

Top module: `tlb_miss_fill`

## Requirements
- R1: After reset, every output is zero and the way pointer is zero.
- R2: Outputs change only on the rising edge that samples `miss_i` high. Without a strobe they hold, even when other inputs change.
- R3: On a miss, `sel_word_o[29:28]` takes `dflt_tsel_i`. All bits other than the entry-select and next-victim fields are zero.
- R4: On a miss, `id_word_o[31]` (valid) is 1 and `id_word_o[11:8]` takes `dflt_size_i`. Every other bit outside the TID and TS fields is zero.
- R5: On a miss, `page_word_o[31:12]` takes `fault_ea_i[31:12]`, `page_word_o[4:0]` takes `dflt_attr_i`, and bits [11:5] are zero.
- R6: On a miss, `rpn_word_o` and `rpnhi_word_o` are cleared to zero.
- R7: The address-space bit is chosen as follows. For a fetch (`acc_i`=2) it is `fetch_as_i`. Otherwise it is `ext_as_i` when `ext_en_i` is set and `data_as_i` when it is not. That bit is copied into `id_word_o[12]` and into `srch_word_o[0]`.
- R8: Outside external-ID mode, `dflt_tidsel_i` picks the missed ID: 0 picks `pid0_i`, 1 picks `pid1_i`, 2 picks `pid2_i`, and 3 gives zero. `srch_word_o[29:16]` always takes `pid0_i` in this mode.
- R9: In external-ID mode, `ext_pid_i` is both the missed ID and the value in `srch_word_o[29:16]`.
- R10: `sel_word_o[19:16]` takes the way pointer as it stood before the miss. The pointer then becomes (pointer+1) modulo 2^`way_lg2_i`, and that new value goes into `sel_word_o[3:0]`.
- R11: `page_bytes_o` becomes 1024 shifted left by `dflt_size_i`.
- R12: `far_o` takes `fault_ea_i`. In `syn_o`, bit 8 is 1 only for stores (`acc_i`=1) and bit 6 is 1 only when `ext_en_i` is set. All other syndrome bits are zero.
- R13: The missed ID is placed in `id_word_o[29:16]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| miss_i | input | 1 | Translation miss strobe |
| fault_ea_i | input | 32 | Faulting effective address |
| acc_i | input | 2 | Access type: 0 load, 1 store, 2 fetch |
| fetch_as_i | input | 1 | Instruction address-space bit |
| data_as_i | input | 1 | Data address-space bit |
| dflt_tsel_i | input | 2 | Default table select |
| dflt_size_i | input | 4 | Default page size code |
| dflt_attr_i | input | 5 | Default storage attributes |
| dflt_tidsel_i | input | 2 | Missed-ID source selector |
| pid0_i | input | 14 | Primary process ID |
| pid1_i | input | 14 | Second process ID |
| pid2_i | input | 14 | Third process ID |
| ext_en_i | input | 1 | External-ID mode |
| ext_pid_i | input | 14 | External process ID |
| ext_as_i | input | 1 | External address-space bit |
| way_lg2_i | input | 3 | log2 of the number of ways |
| sel_word_o | output | 32 | Table select, entry select, next victim |
| id_word_o | output | 32 | Valid, TID, TS, size |
| page_word_o | output | 32 | Page number and attributes |
| rpn_word_o | output | 32 | Real page word (cleared) |
| srch_word_o | output | 32 | Search ID and search address space |
| rpnhi_word_o | output | 32 | Upper real page word (cleared) |
| far_o | output | 32 | Fault address register |
| syn_o | output | 32 | Syndrome |
| page_bytes_o | output | 26 | Default page size in bytes |

## Verification
The way pointer is the only state that persists from one miss to the next. A wrong pointer value, or a wrong wrap, stays hidden until the following miss. At that miss the entry-select field disagrees with the next-victim field captured at the miss before. The bench therefore runs chains of misses across the wrap point and with a single way. Mistakes in field placement or in the ID and address-space selection show up one cycle after the strobe. The bench covers every selector code and every access type so that each of them is seen.

// File: rtl/tmf_pkg.sv
package tmf_pkg;
  localparam int WORD_W = 32;
  localparam int TSZ_W  = 4;
  localparam int ATTR_W = 5;
  localparam int PGB_W  = 11 + (1 << TSZ_W) - 1;

  // field positions inside the assist words
  localparam int TSEL_LSB    = 28;
  localparam int ESEL_LSB    = 16;
  localparam int NV_LSB      = 0;
  localparam int VLD_BIT     = 31;
  localparam int TID_LSB     = 16;
  localparam int TS_BIT      = 12;
  localparam int SIZE_LSB    = 8;
  localparam int SPID_LSB    = 16;
  localparam int SAS_BIT     = 0;
  localparam int SYN_ST_BIT  = 8;
  localparam int SYN_EXT_BIT = 6;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    TSEL_PID0 = 2'd0,
    TSEL_PID1 = 2'd1,
    TSEL_PID2 = 2'd2,
    TSEL_NONE = 2'd3
  } tidsel_e;

  // page size in bytes for a size code: 1 KB times 2^code
  function automatic logic [PGB_W-1:0] size_to_bytes(input logic [TSZ_W-1:0] code);
    logic [PGB_W-1:0] base;
    base = PGB_W'(1024);
    return base << code;
  endfunction

  // effective address-space bit for a miss
  function automatic logic pick_as(input acc_e acc, input logic ias,
                                   input logic das, input logic ext_en,
                                   input logic ext_as);
    if (acc == ACC_FETCH) return ias;
    if (ext_en)           return ext_as;
    return das;
  endfunction
endpackage

// File: rtl/tmf_tid_pick.sv
module tmf_tid_pick #(
  parameter int PID_W = 14
) (
  input  logic [1:0]       tidsel_i,
  input  logic [PID_W-1:0] pid0_i,
  input  logic [PID_W-1:0] pid1_i,
  input  logic [PID_W-1:0] pid2_i,
  input  logic             ext_en_i,
  input  logic [PID_W-1:0] ext_pid_i,
  output logic [PID_W-1:0] tid_o,
  output logic [PID_W-1:0] spid_o
);
  import tmf_pkg::*;

  tidsel_e sel;
  logic [PID_W-1:0] chosen;

  assign sel = tidsel_e'(tidsel_i);

  always_comb begin
    case (sel)
      TSEL_PID0: chosen = pid0_i;
      TSEL_PID1: chosen = pid1_i;
      TSEL_PID2: chosen = pid2_i;
      default:   chosen = '0;
    endcase
  end

  assign tid_o  = ext_en_i ? ext_pid_i : chosen;
  assign spid_o = ext_en_i ? ext_pid_i : pid0_i;
endmodule

// File: rtl/tmf_victim_ptr.sv
module tmf_victim_ptr #(
  parameter int WAYP_W = 4,
  localparam int LG_W = $clog2(WAYP_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,
  input  logic [LG_W-1:0]   lg2_i,
  output logic [WAYP_W-1:0] cur_o,
  output logic [WAYP_W-1:0] nxt_o
);
  logic [WAYP_W-1:0] cur_q;
  logic [WAYP_W-1:0] way_mask;

  // mask of the live pointer bits, one per way-count doubling
  always_comb begin
    for (int b = 0; b < WAYP_W; b++) begin
      way_mask[b] = (b < int'(lg2_i));
    end
  end

  assign nxt_o = (cur_q + 1'b1) & way_mask;
  assign cur_o = cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_q <= '0;
    else if (adv_i)  cur_q <= nxt_o;
  end

  AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i |=> ((cur_q & ~$past(way_mask)) == '0)); // R10
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(cur_q)); // R2
endmodule

// File: rtl/tmf_pack.sv
module tmf_pack #(
  parameter int PID_W   = 14,
  parameter int WAYP_W  = 4,
  parameter int EPN_LSB = 12
) (
  input  logic [tmf_pkg::WORD_W-1:0] ea_i,
  input  logic [1:0]                 acc_i,
  input  logic                       fetch_as_i,
  input  logic                       data_as_i,
  input  logic                       ext_en_i,
  input  logic                       ext_as_i,
  input  logic [1:0]                 tsel_i,
  input  logic [tmf_pkg::TSZ_W-1:0]  size_i,
  input  logic [tmf_pkg::ATTR_W-1:0] attr_i,
  input  logic [PID_W-1:0]           tid_i,
  input  logic [PID_W-1:0]           spid_i,
  input  logic [WAYP_W-1:0]          cur_i,
  input  logic [WAYP_W-1:0]          nxt_i,
  output logic [tmf_pkg::WORD_W-1:0] sel_w_o,
  output logic [tmf_pkg::WORD_W-1:0] id_w_o,
  output logic [tmf_pkg::WORD_W-1:0] page_w_o,
  output logic [tmf_pkg::WORD_W-1:0] srch_w_o,
  output logic [tmf_pkg::WORD_W-1:0] syn_w_o,
  output logic [tmf_pkg::PGB_W-1:0]  pgb_o
);
  import tmf_pkg::*;

  localparam word_t EPN_MASK = ~((word_t'(1) << EPN_LSB) - word_t'(1));

  acc_e acc;
  logic as_bit;

  assign acc    = acc_e'(acc_i);
  assign as_bit = pick_as(acc, fetch_as_i, data_as_i, ext_en_i, ext_as_i);

  assign sel_w_o  = (word_t'(tsel_i) << TSEL_LSB)
                  | (word_t'(cur_i)  << ESEL_LSB)
                  | (word_t'(nxt_i)  << NV_LSB);
  assign id_w_o   = (word_t'(1)      << VLD_BIT)
                  | (word_t'(tid_i)  << TID_LSB)
                  | (word_t'(as_bit) << TS_BIT)
                  | (word_t'(size_i) << SIZE_LSB);
  assign page_w_o = (ea_i & EPN_MASK) | word_t'(attr_i);
  assign srch_w_o = (word_t'(spid_i) << SPID_LSB) | (word_t'(as_bit) << SAS_BIT);
  assign syn_w_o  = (word_t'(acc == ACC_STORE) << SYN_ST_BIT)
                  | (word_t'(ext_en_i)       << SYN_EXT_BIT);
  assign pgb_o    = size_to_bytes(size_i);
endmodule

// File: rtl/tlb_miss_fill.sv
module tlb_miss_fill #(
  parameter int PID_W   = 14,
  parameter int WAYP_W  = 4,
  parameter int EPN_LSB = 12,
  localparam int LG_W   = $clog2(WAYP_W + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       miss_i,
  input  logic [tmf_pkg::WORD_W-1:0] fault_ea_i,
  input  logic [1:0]                 acc_i,
  input  logic                       fetch_as_i,
  input  logic                       data_as_i,
  input  logic [1:0]                 dflt_tsel_i,
  input  logic [tmf_pkg::TSZ_W-1:0]  dflt_size_i,
  input  logic [tmf_pkg::ATTR_W-1:0] dflt_attr_i,
  input  logic [1:0]                 dflt_tidsel_i,
  input  logic [PID_W-1:0]           pid0_i,
  input  logic [PID_W-1:0]           pid1_i,
  input  logic [PID_W-1:0]           pid2_i,
  input  logic                       ext_en_i,
  input  logic [PID_W-1:0]           ext_pid_i,
  input  logic                       ext_as_i,
  input  logic [LG_W-1:0]            way_lg2_i,
  output logic [tmf_pkg::WORD_W-1:0] sel_word_o,
  output logic [tmf_pkg::WORD_W-1:0] id_word_o,
  output logic [tmf_pkg::WORD_W-1:0] page_word_o,
  output logic [tmf_pkg::WORD_W-1:0] rpn_word_o,
  output logic [tmf_pkg::WORD_W-1:0] srch_word_o,
  output logic [tmf_pkg::WORD_W-1:0] rpnhi_word_o,
  output logic [tmf_pkg::WORD_W-1:0] far_o,
  output logic [tmf_pkg::WORD_W-1:0] syn_o,
  output logic [tmf_pkg::PGB_W-1:0]  page_bytes_o
);
  import tmf_pkg::*;

  // named internal events for the assertions
  logic [PID_W-1:0]  tid_w;
  logic [PID_W-1:0]  spid_w;
  logic [WAYP_W-1:0] way_cur_w;
  logic [WAYP_W-1:0] way_nxt_w;
  word_t             sel_n, id_n, page_n, srch_n, syn_n;
  logic [PGB_W-1:0]  pgb_n;

  tmf_tid_pick #(.PID_W(PID_W)) u_tid (
    .tidsel_i (dflt_tidsel_i),
    .pid0_i   (pid0_i),
    .pid1_i   (pid1_i),
    .pid2_i   (pid2_i),
    .ext_en_i (ext_en_i),
    .ext_pid_i(ext_pid_i),
    .tid_o    (tid_w),
    .spid_o   (spid_w)
  );

  tmf_victim_ptr #(.WAYP_W(WAYP_W)) u_way (
    .clk  (clk),
    .rst_n(rst_n),
    .adv_i(miss_i),
    .lg2_i(way_lg2_i),
    .cur_o(way_cur_w),
    .nxt_o(way_nxt_w)
  );

  tmf_pack #(.PID_W(PID_W), .WAYP_W(WAYP_W), .EPN_LSB(EPN_LSB)) u_pack (
    .ea_i      (fault_ea_i),
    .acc_i     (acc_i),
    .fetch_as_i(fetch_as_i),
    .data_as_i (data_as_i),
    .ext_en_i  (ext_en_i),
    .ext_as_i  (ext_as_i),
    .tsel_i    (dflt_tsel_i),
    .size_i    (dflt_size_i),
    .attr_i    (dflt_attr_i),
    .tid_i     (tid_w),
    .spid_i    (spid_w),
    .cur_i     (way_cur_w),
    .nxt_i     (way_nxt_w),
    .sel_w_o   (sel_n),
    .id_w_o    (id_n),
    .page_w_o  (page_n),
    .srch_w_o  (srch_n),
    .syn_w_o   (syn_n),
    .pgb_o     (pgb_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_word_o   <= '0;
      id_word_o    <= '0;
      page_word_o  <= '0;
      rpn_word_o   <= '0;
      srch_word_o  <= '0;
      rpnhi_word_o <= '0;
      far_o        <= '0;
      syn_o        <= '0;
      page_bytes_o <= '0;
    end else if (miss_i) begin
      sel_word_o   <= sel_n;
      id_word_o    <= id_n;
      page_word_o  <= page_n;
      rpn_word_o   <= '0;
      srch_word_o  <= srch_n;
      rpnhi_word_o <= '0;
      far_o        <= fault_ea_i;
      syn_o        <= syn_n;
      page_bytes_o <= pgb_n;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !miss_i |=> ($stable(id_word_o) && $stable(sel_word_o) && $stable(far_o))); // R2
  AST_VALID_SET: assert property (@(posedge clk) disable iff (!rst_n)
    miss_i |=> id_word_o[VLD_BIT]); // R4
  AST_AS_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    miss_i |=> (id_word_o[TS_BIT] == srch_word_o[SAS_BIT])); // R7
  AST_FETCH_AS: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_i && acc_i == 2'd2) |=> (id_word_o[TS_BIT] == $past(fetch_as_i))); // R7
  AST_EXT_TID: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_i && ext_en_i) |=> (id_word_o[TID_LSB +: PID_W] == $past(ext_pid_i))); // R9
  AST_SYN_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    miss_i |=> (syn_o[SYN_ST_BIT] == ($past(acc_i) == 2'd1))); // R12
  AST_ENTRY_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    miss_i |=> (sel_word_o[ESEL_LSB +: WAYP_W] == $past(way_cur_w))); // R10
endmodule

// File: tb/tlb_miss_fill_bench.sv
module tlb_miss_fill_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_i = 1'b0;
  logic [31:0] fault_ea_i = '0;
  logic [1:0]  acc_i = '0;
  logic        fetch_as_i = 1'b0, data_as_i = 1'b0;
  logic [1:0]  dflt_tsel_i = '0;
  logic [3:0]  dflt_size_i = '0;
  logic [4:0]  dflt_attr_i = '0;
  logic [1:0]  dflt_tidsel_i = '0;
  logic [13:0] pid0_i = '0, pid1_i = '0, pid2_i = '0, ext_pid_i = '0;
  logic        ext_en_i = 1'b0, ext_as_i = 1'b0;
  logic [2:0]  way_lg2_i = 3'd4;
  logic [31:0] sel_word_o, id_word_o, page_word_o, rpn_word_o;
  logic [31:0] srch_word_o, rpnhi_word_o, far_o, syn_o;
  logic [25:0] page_bytes_o;

  int n_run = 0, n_fail = 0, m_ptr = 0;
  bit done = 0;
  logic [31:0] e_sel, e_id, e_page, e_srch, e_far, e_syn;
  logic [25:0] e_pgb;

  always #2.5 clk = ~clk;

  tlb_miss_fill u_tlb_miss_fill (
    .clk(clk), .rst_n(rst_n), .miss_i(miss_i), .fault_ea_i(fault_ea_i),
    .acc_i(acc_i), .fetch_as_i(fetch_as_i), .data_as_i(data_as_i),
    .dflt_tsel_i(dflt_tsel_i), .dflt_size_i(dflt_size_i),
    .dflt_attr_i(dflt_attr_i), .dflt_tidsel_i(dflt_tidsel_i),
    .pid0_i(pid0_i), .pid1_i(pid1_i), .pid2_i(pid2_i),
    .ext_en_i(ext_en_i), .ext_pid_i(ext_pid_i), .ext_as_i(ext_as_i),
    .way_lg2_i(way_lg2_i),
    .sel_word_o(sel_word_o), .id_word_o(id_word_o), .page_word_o(page_word_o),
    .rpn_word_o(rpn_word_o), .srch_word_o(srch_word_o),
    .rpnhi_word_o(rpnhi_word_o), .far_o(far_o), .syn_o(syn_o),
    .page_bytes_o(page_bytes_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "sel_word",   64'(sel_word_o),   64'(e_sel));
    chk(tag, "id_word",    64'(id_word_o),    64'(e_id));
    chk(tag, "page_word",  64'(page_word_o),  64'(e_page));
    chk(tag, "srch_word",  64'(srch_word_o),  64'(e_srch));
    chk(tag, "far",        64'(far_o),        64'(e_far));
    chk(tag, "syndrome",   64'(syn_o),        64'(e_syn));
    chk(tag, "page_bytes", 64'(page_bytes_o), 64'(e_pgb));
    chk("R6", "rpn_word",   64'(rpn_word_o),   64'd0);
    chk("R6", "rpnhi_word", 64'(rpnhi_word_o), 64'd0);
  endtask

  // model of one miss, then the strobe, then the comparison
  task automatic fire(input string tag);
    int nw, nx;
    logic as_b;
    logic [13:0] tid;
    nw = 1 << way_lg2_i;
    nx = (m_ptr + 1) % nw;
    if (acc_i == 2'd2)  as_b = fetch_as_i;
    else if (ext_en_i)  as_b = ext_as_i;
    else                as_b = data_as_i;
    if (ext_en_i) tid = ext_pid_i;
    else if (dflt_tidsel_i == 2'd0) tid = pid0_i;
    else if (dflt_tidsel_i == 2'd1) tid = pid1_i;
    else if (dflt_tidsel_i == 2'd2) tid = pid2_i;
    else tid = 14'd0;
    e_sel  = {2'b00, dflt_tsel_i, 8'h00, 4'(m_ptr), 12'h000, 4'(nx)};
    e_id   = {1'b1, 1'b0, tid, 3'b000, as_b, dflt_size_i, 8'h00};
    e_page = {fault_ea_i[31:12], 7'd0, dflt_attr_i};
    e_srch = {2'b00, (ext_en_i ? ext_pid_i : pid0_i), 15'd0, as_b};
    e_far  = fault_ea_i;
    e_syn  = 32'd0;
    e_syn[8] = (acc_i == 2'd1);
    e_syn[6] = ext_en_i;
    e_pgb  = 26'd1 << (10 + int'(dflt_size_i));
    @(negedge clk); miss_i = 1'b1;
    @(negedge clk); miss_i = 1'b0;
    check_all(tag);
    m_ptr = nx;
  endtask

  task automatic t_reset();
    chk("R1", "sel_word",   64'(sel_word_o),   0);
    chk("R1", "id_word",    64'(id_word_o),    0);
    chk("R1", "page_word",  64'(page_word_o),  0);
    chk("R1", "srch_word",  64'(srch_word_o),  0);
    chk("R1", "far",        64'(far_o),        0);
    chk("R1", "syndrome",   64'(syn_o),        0);
    chk("R1", "page_bytes", 64'(page_bytes_o), 0);
  endtask

  task automatic t_defaults();
    fault_ea_i = 32'hDEAD_BEEF; acc_i = 2'd0; data_as_i = 1'b0;
    dflt_tsel_i = 2'd2; dflt_size_i = 4'd3; dflt_attr_i = 5'h15;
    dflt_tidsel_i = 2'd0; pid0_i = 14'h1234; pid1_i = 14'h0AAA; pid2_i = 14'h3555;
    fire("R3 R4 R5 R13");
    fault_ea_i = 32'h0000_0FFF; dflt_tsel_i = 2'd1; dflt_attr_i = 5'h0A;
    fire("R3 R5");
  endtask

  task automatic t_tidsel();
    dflt_tidsel_i = 2'd1; fire("R8 pid1");
    dflt_tidsel_i = 2'd2; fire("R8 pid2");
    dflt_tidsel_i = 2'd3; fire("R8 none");
  endtask

  task automatic t_addr_space();
    dflt_tidsel_i = 2'd0;
    acc_i = 2'd2; fetch_as_i = 1'b1; data_as_i = 1'b0; fire("R7 fetch");
    acc_i = 2'd0; fetch_as_i = 1'b0; data_as_i = 1'b1; fire("R7 data");
    acc_i = 2'd2; fetch_as_i = 1'b0; data_as_i = 1'b1; fire("R7 fetch0");
  endtask

  task automatic t_ext();
    ext_en_i = 1'b1; ext_pid_i = 14'h2BCD; ext_as_i = 1'b1; data_as_i = 1'b0;
    acc_i = 2'd0; dflt_tidsel_i = 2'd2; fire("R9 R7 ext");
    acc_i = 2'd1; fire("R9 R12 ext store");
    ext_en_i = 1'b0; ext_as_i = 1'b0;
  endtask

  task automatic t_syndrome();
    acc_i = 2'd1; fault_ea_i = 32'h8000_1004; fire("R12 store");
    acc_i = 2'd0; fire("R12 load");
  endtask

  task automatic t_hold();
    fault_ea_i = 32'h1111_2222; acc_i = 2'd1; pid0_i = 14'h0001;
    dflt_size_i = 4'd9; ext_en_i = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R2 hold");
    ext_en_i = 1'b0;
  endtask

  task automatic t_size();
    dflt_size_i = 4'd0;  fire("R11 min");
    dflt_size_i = 4'd15; fire("R11 max");
  endtask

  task automatic t_ways();
    way_lg2_i = 3'd0; fire("R10 one way"); fire("R10 one way again");
    way_lg2_i = 3'd2;
    for (int k = 0; k < 5; k++) fire("R10 wrap4");
    way_lg2_i = 3'd4;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_defaults();
    t_tidsel();
    t_addr_space();
    t_ext();
    t_syndrome();
    t_hold();
    t_size();
    t_ways();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule